// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block keeps an 11-bit index register and turns it, together with an 8-bit unsigned offset from the current instruction, into a 12-bit physical address. The top index bit does not count. It only chooses the target space. With that bit clear, the address lands in a low data window starting at 0x000. With it set, the same 10-bit location is moved into a program window that starts at 0xC00. A space-select output tells the memory system which space is meant. Data-space results above 0x0FF raise an out-of-range flag.

The register can be loaded in three ways:
- A dedicated instruction path loads all 11 bits in one cycle.
- Two byte locations in the memory-mapped register space write the register a byte at a time.
- A counter input increments the low 10 bits.

The same byte locations can be read. The space-select bit is write-only, so it always reads back as zero. Address requests are registered and answered one cycle later. Each request uses the index value held before the clock edge that takes the request.

Top module: `idx_ea_gen`

## Requirements
- R1: After reset the index register is 0x000 and `ea_valid_o`, `ea_prog_o`, `ea_oor_o` and `ea_addr_o` are all 0.
- R2: A full load (`xload_valid_i`) writes all 11 bits from `xload_data_i`. It wins over a byte write and over an increment in the same cycle.
- R3: A byte write to address 0xBE loads index bits 10:8 from `mm_wdata_i[2:0]`. A byte write to 0xBF loads bits 7:0 from `mm_wdata_i`. A write to any other address changes nothing.
- R4: Reads are combinational and flagged by `mm_hit_o`=1. Address 0xBE returns {6'b0, index[9:8]}, so index bit 10 always reads as 0. Address 0xBF returns index[7:0]. Any other address returns 0x00 with `mm_hit_o`=0.
- R5: `cnt_inc_i` adds 1 to index bits 9:0, modulo 1024, and leaves bit 10 unchanged. An increment yields to a full load or byte write in the same cycle.
- R6: When `ea_req_i` is high at a clock edge, `ea_valid_o` is 1 after that edge. `ea_addr_o[9:0]` is then (index[9:0] + `offset_i`) mod 1024, using the index value from before the edge, and no carry ever reaches bit 10.
- R7: If index bit 10 is 1, then `ea_prog_o`=1, `ea_addr_o` = 0xC00 + sum, and `ea_oor_o`=0.
- R8: If index bit 10 is 0, then `ea_prog_o`=0, `ea_addr_o` = sum with bits 11:10 at zero, and `ea_oor_o`=1 exactly when the sum exceeds 0x0FF.
- R9: After an edge where `ea_req_i` is low, `ea_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xload_valid_i | input | 1 | Full 11-bit index load strobe |
| xload_data_i | input | 11 | Full load value |
| mm_wr_i | input | 1 | Memory-mapped byte write strobe |
| mm_addr_i | input | 8 | Memory-mapped address, used for reads and writes |
| mm_wdata_i | input | 8 | Memory-mapped write data |
| cnt_inc_i | input | 1 | Increment the low 10 index bits |
| ea_req_i | input | 1 | Effective address request |
| offset_i | input | 8 | Unsigned instruction offset |
| mm_rdata_o | output | 8 | Memory-mapped read data |
| mm_hit_o | output | 1 | Read address matches an index byte |
| ea_valid_o | output | 1 | Effective address valid |
| ea_addr_o | output | 12 | Physical address |
| ea_prog_o | output | 1 | Space select: 1 program, 0 data |
| ea_oor_o | output | 1 | Data-space address above 0x0FF |

## Verification
Address results are due one edge after their request. The driver sets each request at a falling edge and pushes the expected address, space and range values, all computed from its own model of the index. A monitor checks these values at the next falling edge, when the output register has settled.

Register loads, byte writes and increments take effect at the next rising edge. The combinational reads that observe them are therefore sampled 1 ns after a falling edge, well away from any clock edge. The case where a load and a request fall in the same cycle is checked to confirm that the request uses the old index value.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int IDX_W = 11;
  localparam int LOC_W = IDX_W - 1;
  localparam int SEL_B = IDX_W - 1;
  localparam int HI_W  = IDX_W - 8;
  localparam int OFS_W = 8;
  localparam int PA_W  = 12;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [PA_W-1:0] addr;
    logic            prog;
    logic            oor;
  } ea_res_t;
endpackage

// File: rtl/idx_reg.sv
module idx_reg
  import idx_ea_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_data_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] idx_q;

  // priority: full load > byte write > increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (load_i) begin
      idx_q <= load_data_i;
    end else if (wr_hi_i || wr_lo_i) begin
      if (wr_hi_i) idx_q[IDX_W-1:8] <= wdata_i[HI_W-1:0];
      if (wr_lo_i) idx_q[7:0]       <= wdata_i;
    end else if (inc_i) begin
      idx_q[LOC_W-1:0] <= idx_q[LOC_W-1:0] + LOC_W'(1);
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/idx_mm_port.sv
module idx_mm_port
  import idx_ea_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HI_ADDR = 8'hBE,
  parameter logic [BYTE_W-1:0] LO_ADDR = 8'hBF
) (
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              hit_o
);
  logic sel_hi, sel_lo;

  assign sel_hi  = (addr_i == HI_ADDR);
  assign sel_lo  = (addr_i == LO_ADDR);
  assign wr_hi_o = wr_i && sel_hi;
  assign wr_lo_o = wr_i && sel_lo;
  assign hit_o   = sel_hi || sel_lo;

  // space-select bit is write-only: read as zero
  always_comb begin
    rdata_o = '0;
    if (sel_hi)      rdata_o = {{(BYTE_W-HI_W+1){1'b0}}, idx_i[SEL_B-1:8]};
    else if (sel_lo) rdata_o = idx_i[7:0];
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter logic [PA_W-1:0]  PROG_BASE = 12'hC00,
  parameter logic [LOC_W-1:0] DATA_TOP  = 10'h0FF
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OFS_W-1:0] offset_i,
  output ea_res_t          res_o
);
  logic [LOC_W-1:0] loc_sum;
  logic             prog;

  // wraps inside the location field, never touches the selector
  assign loc_sum = idx_i[LOC_W-1:0] + {{(LOC_W-OFS_W){1'b0}}, offset_i};
  assign prog    = idx_i[SEL_B];

  always_comb begin
    res_o.prog = prog;
    if (prog) begin
      res_o.addr = PROG_BASE + {{(PA_W-LOC_W){1'b0}}, loc_sum};
      res_o.oor  = 1'b0;
    end else begin
      res_o.addr = {{(PA_W-LOC_W){1'b0}}, loc_sum};
      res_o.oor  = (loc_sum > DATA_TOP);
    end
  end
endmodule

// File: rtl/idx_ea_out.sv
module idx_ea_out
  import idx_ea_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  ea_res_t res_i,
  output logic    valid_o,
  output ea_res_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HI_ADDR   = 8'hBE,
  parameter logic [BYTE_W-1:0] LO_ADDR   = 8'hBF,
  parameter logic [PA_W-1:0]   PROG_BASE = 12'hC00,
  parameter logic [LOC_W-1:0]  DATA_TOP  = 10'h0FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xload_valid_i,
  input  logic [IDX_W-1:0]  xload_data_i,
  input  logic              mm_wr_i,
  input  logic [BYTE_W-1:0] mm_addr_i,
  input  logic [BYTE_W-1:0] mm_wdata_i,
  input  logic              cnt_inc_i,
  input  logic              ea_req_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [BYTE_W-1:0] mm_rdata_o,
  output logic              mm_hit_o,
  output logic              ea_valid_o,
  output logic [PA_W-1:0]   ea_addr_o,
  output logic              ea_prog_o,
  output logic              ea_oor_o
);
  logic [IDX_W-1:0] idx_q;
  logic             wr_hi, wr_lo;
  ea_res_t          ea_comb, ea_q;

  idx_mm_port #(.HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_mm (
    .wr_i   (mm_wr_i),
    .addr_i (mm_addr_i),
    .idx_i  (idx_q),
    .wr_hi_o(wr_hi),
    .wr_lo_o(wr_lo),
    .rdata_o(mm_rdata_o),
    .hit_o  (mm_hit_o)
  );

  idx_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (xload_valid_i),
    .load_data_i(xload_data_i),
    .wr_hi_i    (wr_hi),
    .wr_lo_i    (wr_lo),
    .wdata_i    (mm_wdata_i),
    .inc_i      (cnt_inc_i),
    .idx_o      (idx_q)
  );

  idx_ea_calc #(.PROG_BASE(PROG_BASE), .DATA_TOP(DATA_TOP)) u_calc (
    .idx_i   (idx_q),
    .offset_i(offset_i),
    .res_o   (ea_comb)
  );

  idx_ea_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ea_req_i),
    .res_i  (ea_comb),
    .valid_o(ea_valid_o),
    .res_o  (ea_q)
  );

  assign ea_addr_o = ea_q.addr;
  assign ea_prog_o = ea_q.prog;
  assign ea_oor_o  = ea_q.oor;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        xload_valid_i,
  input logic [10:0] xload_data_i,
  input logic        mm_wr_i,
  input logic [7:0]  mm_addr_i,
  input logic        cnt_inc_i,
  input logic        ea_req_i,
  input logic [7:0]  offset_i,
  input logic [7:0]  mm_rdata_o,
  input logic        mm_hit_o,
  input logic        ea_valid_o,
  input logic [11:0] ea_addr_o,
  input logic        ea_prog_o,
  input logic        ea_oor_o,
  input logic [10:0] idx_q
);
  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xload_valid_i |=> idx_q == $past(xload_data_i));

  a_r5_inc_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_inc_i && !xload_valid_i && !mm_wr_i) |=>
      (idx_q[10] == $past(idx_q[10])) && (idx_q[9:0] == $past(idx_q[9:0]) + 10'd1));

  a_r4_sel_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_hit_o && mm_addr_i == 8'hBE) |-> mm_rdata_o[7:2] == 6'd0);

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_req_i |=> ea_valid_o);

  a_r6_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_req_i |=> ea_addr_o[9:0] == $past(idx_q[9:0]) + {2'b00, $past(offset_i)});

  a_r7_prog_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && ea_prog_o) |-> (ea_addr_o[11:10] == 2'b11) && !ea_oor_o);

  a_r8_data_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && !ea_prog_o) |->
      (ea_addr_o[11:10] == 2'b00) && (ea_oor_o == (ea_addr_o[9:0] > 10'h0FF)));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ea_req_i |=> !ea_valid_o);
endmodule

bind idx_ea_gen idx_ea_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xload_valid_i(xload_valid_i),
  .xload_data_i (xload_data_i),
  .mm_wr_i      (mm_wr_i),
  .mm_addr_i    (mm_addr_i),
  .cnt_inc_i    (cnt_inc_i),
  .ea_req_i     (ea_req_i),
  .offset_i     (offset_i),
  .mm_rdata_o   (mm_rdata_o),
  .mm_hit_o     (mm_hit_o),
  .ea_valid_o   (ea_valid_o),
  .ea_addr_o    (ea_addr_o),
  .ea_prog_o    (ea_prog_o),
  .ea_oor_o     (ea_oor_o),
  .idx_q        (idx_q)
);

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xload_valid = 1'b0;
  logic [10:0] xload_data = '0;
  logic        mm_wr = 1'b0;
  logic [7:0]  mm_addr = '0;
  logic [7:0]  mm_wdata = '0;
  logic        cnt_inc = 1'b0;
  logic        ea_req = 1'b0;
  logic [7:0]  offset = '0;
  logic [7:0]  mm_rdata;
  logic        mm_hit;
  logic        ea_valid;
  logic [11:0] ea_addr;
  logic        ea_prog;
  logic        ea_oor;

  int checks = 0;
  int failures = 0;
  logic [10:0] idx_m = '0;

  typedef struct {
    logic [11:0] addr;
    logic        prog;
    logic        oor;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  idx_ea_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .xload_valid_i(xload_valid), .xload_data_i(xload_data),
    .mm_wr_i(mm_wr), .mm_addr_i(mm_addr), .mm_wdata_i(mm_wdata),
    .cnt_inc_i(cnt_inc), .ea_req_i(ea_req), .offset_i(offset),
    .mm_rdata_o(mm_rdata), .mm_hit_o(mm_hit),
    .ea_valid_o(ea_valid), .ea_addr_o(ea_addr),
    .ea_prog_o(ea_prog), .ea_oor_o(ea_oor)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model_ea(input logic [10:0] idx, input logic [7:0] ofs);
    exp_t e;
    logic [9:0] s;
    s = idx[9:0] + {2'b00, ofs};
    e.prog = idx[10];
    e.addr = idx[10] ? (12'hC00 + {2'b00, s}) : {2'b00, s};
    e.oor  = !idx[10] && (s > 10'h0FF);
    return e;
  endfunction

  // one cycle of stimulus; model follows the required priority
  task automatic drive(input bit ld, input logic [10:0] ld_d, input bit wr,
                       input logic [7:0] wa, input logic [7:0] wd, input bit inc,
                       input bit req, input logic [7:0] ofs);
    @(negedge clk);
    xload_valid = ld; xload_data = ld_d;
    mm_wr = wr; mm_addr = wa; mm_wdata = wd;
    cnt_inc = inc; ea_req = req; offset = ofs;
    if (req) sb_q.push_back(model_ea(idx_m, ofs));
    if (ld) idx_m = ld_d;
    else if (wr && (wa == 8'hBE || wa == 8'hBF)) begin
      if (wa == 8'hBE) idx_m[10:8] = wd[2:0];
      else             idx_m[7:0]  = wd;
    end else if (inc) idx_m[9:0] = idx_m[9:0] + 10'd1;
    @(posedge clk);
    #1;
    xload_valid = 1'b0; mm_wr = 1'b0; cnt_inc = 1'b0; ea_req = 1'b0;
  endtask

  task automatic load(input logic [10:0] d);
    drive(1'b1, d, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic ea(input logic [7:0] ofs);
    drive(1'b0, 11'h0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, ofs);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp_d, input bit exp_hit, input string tag);
    @(negedge clk);
    mm_addr = a;
    #1;
    check(mm_rdata == exp_d, tag, int'(mm_rdata), int'(exp_d));
    check(mm_hit == exp_hit, {tag, " hit"}, int'(mm_hit), int'(exp_hit));
  endtask

  // monitor: compare each valid result with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && ea_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(ea_addr == e.addr, e.prog ? "R7 addr" : "R8 addr", int'(ea_addr), int'(e.addr));
        check(ea_prog == e.prog, "R6 prog", int'(ea_prog), int'(e.prog));
        check(ea_oor == e.oor, e.prog ? "R7 oor" : "R8 oor", int'(ea_oor), int'(e.oor));
      end
    end
  end

  initial begin
    #(20 * 5000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(ea_valid == 1'b0, "R1 valid", int'(ea_valid), 0);
    check(ea_addr == 12'h000, "R1 addr", int'(ea_addr), 0);
    check({ea_prog, ea_oor} == 2'b00, "R1 flags", int'({ea_prog, ea_oor}), 0);
    rst_n = 1'b1;
    rd(8'hBE, 8'h00, 1'b1, "R1 hi");
    rd(8'hBF, 8'h00, 1'b1, "R1 lo");

    // R2 full load, R4 read with hidden selector
    load(11'h5A3);
    rd(8'hBE, 8'h01, 1'b1, "R4 hi");
    rd(8'hBF, 8'hA3, 1'b1, "R4 lo");
    ea(8'h10);                    // R7 0xDB3
    load(11'h7F0);
    ea(8'h20);                    // R6 wrap 0xC10, no carry
    load(11'h0F0);
    ea(8'h0F);                    // R8 0x0FF in range
    ea(8'h10);                    // R8 0x100 out of range
    load(11'h3FF);
    ea(8'hFF);                    // R6 wrap to 0x0FE

    // R9 idle cycle
    @(negedge clk);
    @(negedge clk);
    check(ea_valid == 1'b0, "R9 idle", int'(ea_valid), 0);

    // R3 byte writes
    drive(1'b0, 11'h0, 1'b1, 8'hBE, 8'hFC, 1'b0, 1'b0, 8'h00);
    drive(1'b0, 11'h0, 1'b1, 8'hBF, 8'h55, 1'b0, 1'b0, 8'h00);
    rd(8'hBE, 8'h00, 1'b1, "R3 hi");
    rd(8'hBF, 8'h55, 1'b1, "R3 lo");
    ea(8'h00);                    // R3 selector set: 0xC55
    drive(1'b0, 11'h0, 1'b1, 8'hBD, 8'hFF, 1'b0, 1'b0, 8'h00);
    rd(8'hBF, 8'h55, 1'b1, "R3 ignored lo");
    rd(8'hBE, 8'h00, 1'b1, "R3 ignored hi");
    rd(8'hBD, 8'h00, 1'b0, "R4 miss");
    ea(8'h00);                    // R3 still 0xC55

    // R5 increment
    load(11'h7FF);
    drive(1'b0, 11'h0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    rd(8'hBE, 8'h00, 1'b1, "R5 wrap hi");
    rd(8'hBF, 8'h00, 1'b1, "R5 wrap lo");
    ea(8'h00);                    // R5 selector kept: 0xC00
    load(11'h0FF);
    drive(1'b0, 11'h0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
    rd(8'hBE, 8'h01, 1'b1, "R5 carry hi");
    ea(8'h00);                    // R8 0x100 out of range

    // R2 priority over byte write and increment
    drive(1'b1, 11'h123, 1'b1, 8'hBF, 8'hEE, 1'b1, 1'b0, 8'h00);
    rd(8'hBF, 8'h23, 1'b1, "R2 load wins");
    rd(8'hBE, 8'h01, 1'b1, "R2 load hi");
    // R5 byte write beats increment
    drive(1'b0, 11'h0, 1'b1, 8'hBF, 8'h10, 1'b1, 1'b0, 8'h00);
    rd(8'hBF, 8'h10, 1'b1, "R5 write wins");

    // R6 request uses index from before a same-cycle load
    drive(1'b1, 11'h7FF, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h01);
    // R6 back-to-back requests
    ea(8'h00);
    ea(8'h01);
    ea(8'h80);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R6 all results seen", sb_q.size(), 0);
    check(ea_valid == 1'b0, "R9 final idle", int'(ea_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule